// File: doc/BRIEF.md
# Serial DAC input receiver

This block is the digital front end of a 16-bit converter with a serial input. It takes three asynchronous lines: a bit clock, a data line and a latch-enable line. All three are sampled by a fast system clock. A data bit moves into a shift register when the bit clock falls. The newest bit enters at the least significant end, so a word that is sent sign bit first finishes in its natural order.

A falling latch enable copies the sixteen most recent bits into a holding register, which drives the converter core. No bit counter and no framing are involved. A latch always takes whatever the last sixteen falling bit-clock edges delivered. The block presents three outputs:
- the held two's-complement word;
- an offset-binary copy of that word, where all zeros in two's complement maps to midscale;
- a strobe one system clock wide that marks each load of the holding register.

Top module: `sdac_rx`

## Requirements
- R1: While reset is low, and on the first system clock after it goes low, `word_o` is 0x0000, `word_ob_o` is 0x8000 and `upd_o` is 0. Reset also clears the shift register to all zeros.
- R2: On each falling edge of `sclk_i`, the shift register moves one place toward the MSB and takes the `sdat_i` value at its LSB. A word sent MSB first over 16 falling edges, and then latched, appears unchanged on `word_o`.
- R3: Changes on `sdat_i` while `sclk_i` is high, and rising edges of `sclk_i`, put no bit into the shift register.
- R4: If more than 16 bits arrive between latches, a latch captures only the last 16.
- R5: If n < 16 bits arrive after the previous capture, a latch captures the older shift-register contents moved up by n places, with the n new bits below them.
- R6: Each falling edge of `sle_i` gives exactly one `upd_o` pulse, one system clock wide. A rising edge of `sle_i` gives no pulse, and neither does holding `sle_i` low while bits arrive.
- R7: `word_o` changes only in a cycle where `upd_o` is 1. Bits shifted in between latches do not reach it.
- R8: `word_ob_o` is `word_o` with bit 15 inverted. Its unsigned value equals the signed value of `word_o` plus 32768.
- R9: If the falling edges of `sclk_i` and `sle_i` reach the block in the same system clock, the latched word includes the bit shifted by that edge.
- R10: After an input edge that occurs between system clock edges, the shift register, `word_o` and `upd_o` respond at the third rising system clock edge: two synchronizer stages plus one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial bit clock; data is taken on its falling edge |
| sdat_i | input | 1 | Serial data, MSB first |
| sle_i | input | 1 | Latch enable; its falling edge loads the holding register |
| word_o | output | 16 | Held two's-complement word |
| word_ob_o | output | 16 | Held word in offset binary |
| upd_o | output | 1 | One-cycle pulse that marks a load of the holding register |

## Verification
The bench changes serial inputs only on falling system clock edges. A latch-enable fall is therefore seen at the third rising edge after it, and the bench samples at the falling edges between rising edges. It checks that `word_o` still holds the old value at the second sample and the new value at the third. It checks that `upd_o` is high at the third sample and low again at the fourth. Bit timing keeps every data bit stable from three cycles before its clock fall until well after the clock rises, so each captured bit is unambiguous. A reference shift register in the bench predicts the value of every latch.

// File: rtl/sdac_rx_pkg.sv
package sdac_rx_pkg;
   // Convert a two's-complement word to offset binary.
   function automatic logic [15:0] to_offset16(input logic [15:0] w);
      logic [15:0] r;
      r = w + 16'h8000;
      return r;
   endfunction

   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
   parameter int W      = 3,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("sdac_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st[0] <= '0;
      else        st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_st
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) st[i] <= '0;
         else        st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
   import sdac_rx_pkg::*;
#(
   parameter int         W    = 2,
   parameter edge_kind_e KIND = EDGE_FALL
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] hit
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= lvl;
   end

   generate
      if (KIND == EDGE_FALL) begin : g_fall
         assign hit = prev_q & ~lvl;
      end else begin : g_rise
         assign hit = ~prev_q & lvl;
      end
   endgenerate
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   input  logic         load_en,
   output logic [W-1:0] sh_q,
   output logic [W-1:0] hold_q,
   output logic         upd_q
);
   generate
      if (W < 2) begin : g_bad
         $error("sdac_shift: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sh_next;
   logic [W-1:0] load_val;

   always_comb begin
      sh_next  = {sh_q[W-2:0], din};
      // A bit that arrives on the same cycle as a latch is included.
      load_val = shift_en ? sh_next : sh_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (shift_en) sh_q <= sh_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         upd_q  <= 1'b0;
      end else begin
         upd_q <= load_en;
         if (load_en) hold_q <= load_val;
      end
   end
endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
   import sdac_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sclk_i,
   input  logic        sdat_i,
   input  logic        sle_i,
   output logic [15:0] word_o,
   output logic [15:0] word_ob_o,
   output logic        upd_o
);
   localparam int WORD_W = 16;
   localparam int NLINE  = 3;

   logic [NLINE-1:0] raw_v, syn_v;
   logic             clk_s, dat_s, le_s;
   logic [1:0]       fall_v;
   logic [WORD_W-1:0] sh_q;

   assign raw_v = {sle_i, sdat_i, sclk_i};

   sdac_sync #(.W(NLINE), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
   );

   assign clk_s = syn_v[0];
   assign dat_s = syn_v[1];
   assign le_s  = syn_v[2];

   sdac_edge #(.W(2), .KIND(EDGE_FALL)) u_edge (
      .clk(clk), .rst_n(rst_n), .lvl({le_s, clk_s}), .hit(fall_v)
   );

   sdac_shift #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .shift_en(fall_v[0]), .din(dat_s), .load_en(fall_v[1]),
      .sh_q(sh_q), .hold_q(word_o), .upd_q(upd_o)
   );

   assign word_ob_o = to_offset16(word_o);
endmodule

// File: rtl/sdac_rx_chk.sv
module sdac_rx_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         clk_s,
   input logic         dat_s,
   input logic         le_s,
   input logic [W-1:0] sh_q,
   input logic [W-1:0] word_o,
   input logic [W-1:0] word_ob_o,
   input logic         upd_o
);
   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |=> (word_o == '0 && !upd_o));

   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_s) |=> (sh_q == {$past(sh_q[W-2:0]), $past(dat_s)}));

   a_r6_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(le_s) |=> upd_o);

   a_r6_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);

   a_r7_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> $stable(word_o));

   a_r8_offset: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(signed'(word_o)) + 32'(1 << (W-1))) == {{(32-W){1'b0}}, word_ob_o});
endmodule

bind sdac_rx sdac_rx_chk #(.W(16)) u_chk (
   .clk(clk), .rst_n(rst_n), .clk_s(clk_s), .dat_s(dat_s), .le_s(le_s),
   .sh_q(sh_q), .word_o(word_o), .word_ob_o(word_ob_o), .upd_o(upd_o)
);

// File: tb/sdac_rx_tb.sv
module sdac_rx_tb;
   localparam time CLK_PERIOD = 10ns;
   localparam int  NVEC = 6;
   localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'h8000, 16'h7FFF,
                                          16'hFFFF, 16'h1234, 16'hA5C3};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b1, sdat = 1'b0, sle = 1'b1;
   logic [15:0] word, word_ob;
   logic upd;
   int n_chk = 0, n_err = 0, upd_cnt = 0;
   logic [15:0] model = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdac_rx u_dut (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat), .sle_i(sle),
      .word_o(word), .word_ob_o(word_ob), .upd_o(upd)
   );

   always @(posedge clk) if (upd === 1'b1) upd_cnt <= upd_cnt + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // One bit: data stable 3 cycles before the fall; glitch while high if asked (R3)
   task automatic send_bit(input logic b, input logic glitch);
      @(negedge clk); sdat = b;
      wait_n(3); sclk = 1'b0;
      wait_n(4); sclk = 1'b1;
      wait_n(2);
      if (glitch) begin sdat = ~b; wait_n(2); sdat = b; wait_n(1); end
      model = {model[14:0], b};
   endtask

   task automatic send_word(input logic [15:0] w, input int nbits, input logic glitch);
      for (int i = nbits - 1; i >= 0; i--) send_bit(w[i], glitch);
   endtask

   // Latch with cycle-exact checks (R10, R6, R7)
   task automatic latch(input string req, input logic [15:0] exp);
      logic [15:0] old;
      int c0;
      old = word; c0 = upd_cnt;
      @(negedge clk); sle = 1'b0;
      wait_n(2);
      chk({req, " R10 word before 3rd edge"}, word, old);
      wait_n(1);
      chk({req, " word"}, word, exp);
      chk({req, " R8 offset"}, word_ob, exp ^ 16'h8000);
      chk({req, " R6 upd high"}, upd, 1'b1);
      wait_n(1);
      chk({req, " R6 upd one cycle"}, upd, 1'b0);
      wait_n(2); sle = 1'b1;
      wait_n(6);
      chk({req, " R6 one pulse"}, upd_cnt - c0, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_err++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      // R1 reset state
      wait_n(3);
      chk("R1 word", word, 16'h0000);
      chk("R1 offset", word_ob, 16'h8000);
      chk("R1 upd", upd, 1'b0);
      rst_n = 1'b1;
      wait_n(4);

      // R2 vector table, plus R3 glitches on odd entries
      for (int v = 0; v < NVEC; v++) begin
         send_word(VEC[v], 16, logic'(v % 2));
         latch("R2 vector", VEC[v]);
      end

      // R4: 20 bits, only the last 16 kept
      send_word(16'h000B, 4, 1'b0);
      send_word(16'hC3A5, 16, 1'b0);
      latch("R4 overlong", 16'hC3A5);

      // R5: 5 bits after a latch
      send_word(16'h0013, 5, 1'b0);
      latch("R5 short", {16'hC3A5 << 5} | 16'h0013);
      chk("R5 model", word, model);

      // R7 and R6: bits shifted with LE held high, then with LE held low
      begin
         int c0;
         logic [15:0] hold;
         hold = word; c0 = upd_cnt;
         send_word(16'h5555, 8, 1'b0);
         chk("R7 word unchanged while shifting", word, hold);
         @(negedge clk); sle = 1'b0;
         wait_n(5);
         hold = word; c0 = upd_cnt;
         send_word(16'h00F0, 8, 1'b0);
         chk("R6 LE held low no load", word, hold);
         @(negedge clk); sle = 1'b1;
         wait_n(6);
         chk("R6 LE rise no load", word, hold);
         chk("R6 no pulse for held/rising LE", upd_cnt - c0, 0);
      end

      // R9: clock fall and LE fall in the same cycle
      send_word(16'h6B2D >> 1, 15, 1'b0);
      @(negedge clk); sdat = 1'b1;
      wait_n(3); sclk = 1'b0; sle = 1'b0;
      model = {model[14:0], 1'b1};
      wait_n(3);
      chk("R9 coincident bit included", word, model);
      chk("R9 coincident value", word, 16'h6B2D);
      wait_n(3); sclk = 1'b1; sle = 1'b1;
      wait_n(4);

      // R1 mid-run reset clears outputs and shift register
      @(negedge clk); rst_n = 1'b0;
      wait_n(2);
      chk("R1 mid-run word", word, 16'h0000);
      chk("R1 mid-run offset", word_ob, 16'h8000);
      rst_n = 1'b1; model = '0;
      wait_n(4);
      send_word(16'h0009, 4, 1'b0);
      latch("R1 R5 cleared shift register", 16'h0009);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule